// File: doc/BRIEF.md
# DMA Stream with Width Packing

This block is a single DMA channel that copies a programmed number of bytes from a source to a destination. The read side and the write side each have their own access size (byte, halfword or word) and their own address mode (stepping or fixed). Data passes through an internal buffer of sixteen 32-bit words. The buffer is managed one byte at a time, so any mix of source and destination sizes packs or unpacks correctly, in little-endian order.

Software-side logic loads the configuration inputs and pulses `start`. The stream then issues bursts on a read port and a write port. Each port uses a request/grant handshake: a beat completes in any cycle where request and grant are both high, and read data and error responses are sampled in that cycle. A peripheral request input paces the peripheral side in the two peripheral modes. When the stream ends, either normally or after an error response, it raises `done`, optionally `err`, and a one-cycle `irq` pulse.

Top module: `dma_pack_stream`

## Requirements
- R1: During and immediately after reset, `rd_req`, `wr_req`, `busy`, `done`, `err` and `irq` are all low.
- R2: `cfg_mode` selects the flow control: 0 is memory to memory (both sides run freely), 1 is peripheral to memory (a read burst may begin only at a clock edge where `periph_req` is high), and 2 is memory to peripheral (a write burst may begin only at a clock edge where `periph_req` is high). In memory-to-memory mode, `rd_req` first rises two edges after the edge that samples `start`.
- R3: Size codes are 0 for byte, 1 for halfword and 2 for word, on both `cfg_src_size` and `cfg_dst_size`. On both ports the element sits right-justified in bits [8n-1:0] of the 32-bit data. Read lanes above the element are ignored, and write lanes above the element are driven to zero. `rd_size` and `wr_size` carry the programmed code on every beat.
- R4: The bytes written to the destination are exactly the bytes read from the source, in the same order, for every pair of sizes. The first-read byte of a word sits in bits 7:0, so packing is little-endian.
- R5: With its increment bit set, a side's address advances by 1, 2 or 4 (its access size in bytes) after each completed beat. With the bit clear, the address stays at its programmed value.
- R6: A burst has min(`cfg_burst_m1`+1, remaining beats) beats. A read burst starts only when the 64-byte buffer has room for the whole burst, and a write burst starts only when the buffer already holds the whole burst.
- R7: After the last write beat completes, `done` rises two edges later, together with a one-cycle `irq` pulse, and `busy` falls at that same edge. `done` holds until the next `start`. While `done` is high, neither port requests.
- R8: An error response (`rd_err` or `wr_err` on a completed beat) ends the stream at that edge. At the next cycle `done`, `err` and a one-cycle `irq` are high and neither port requests again.
- R9: A byte count of zero completes with no port access, and `done` rises two edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latches the configuration and begins a stream |
| cfg_mode | input | 2 | Flow-control mode: 0 mem-mem, 1 periph-mem, 2 mem-periph |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_src_inc | input | 1 | Source address steps after each beat |
| cfg_dst_inc | input | 1 | Destination address steps after each beat |
| cfg_src_size | input | 2 | Source access size code |
| cfg_dst_size | input | 2 | Destination access size code |
| cfg_burst_m1 | input | BURST_W | Burst length in beats, minus one |
| cfg_bytes | input | CW | Total bytes to move, a multiple of the larger access size |
| periph_req | input | 1 | Peripheral request pacing the peripheral side |
| rd_req | output | 1 | Read beat request |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read size code |
| rd_gnt | input | 1 | Read grant; the beat completes when request and grant are both high |
| rd_data | input | 32 | Read data, right-justified |
| rd_err | input | 1 | Error response on the completing read beat |
| wr_req | output | 1 | Write beat request |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write size code |
| wr_data | output | 32 | Write data, right-justified, upper lanes zero |
| wr_gnt | input | 1 | Write grant |
| wr_err | input | 1 | Error response on the completing write beat |
| busy | output | 1 | Stream in progress |
| done | output | 1 | Stream finished, held until the next start |
| err | output | 1 | Stream ended on an error response |
| irq | output | 1 | One-cycle pulse when the stream ends |

## Verification
Each result has a fixed latency. The first read request appears two edges after `start` is sampled, `done` follows the last completed write by two edges, and it follows an erroring beat by one edge. Bursts granted by a single-cycle `periph_req` pulse complete well inside the 60-cycle pulse period. The bench records the cycle number of every completed beat at the falling edge, when request, grant and data are all stable. It then compares cycle differences against these exact offsets, rather than polling for an eventual value. Byte streams, addresses, size codes and per-pulse beat counts are worked out from the configuration alone, across all nine size pairs, three modes and two burst lengths, with grants stalled in a pseudo-random pattern.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;

  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_HALF = 2'd1,
    XS_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    MODE_M2M = 2'd0,
    MODE_P2M = 2'd1,
    MODE_M2P = 2'd2
  } xfer_mode_e;

  // Bytes carried by one beat of the given size code.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      XS_BYTE: size_bytes = 3'd1;
      XS_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Lane mask for a right-justified element of the given size code.
  function automatic logic [31:0] lane_mask(input logic [1:0] code);
    case (code)
      XS_BYTE: lane_mask = 32'h0000_00FF;
      XS_HALF: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_pack_fifo.sv
module dma_pack_fifo #(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [2:0]                 push_n,
  input  logic [31:0]                push_data,
  input  logic                       pop,
  input  logic [2:0]                 pop_n,
  output logic [31:0]                head,
  output logic [$clog2(DEPTH):0]     count,
  output logic [$clog2(DEPTH):0]     free
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CNTW = PW + 1;

  logic [7:0]      mem [DEPTH];
  logic [PW-1:0]   wptr_q, wptr_d;
  logic [PW-1:0]   rptr_q, rptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  // Byte storage: no reset, written lane by lane on push
  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < 4; i++) begin
        if (3'(i) < push_n) mem[wptr_q + PW'(i)] <= push_data[8*i +: 8];
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_head
    assign head[8*g +: 8] = mem[rptr_q + PW'(g)];
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = wptr_q + PW'(push_n);
      if (pop)  rptr_d = rptr_q + PW'(pop_n);
      cnt_d = cnt_q + (push ? CNTW'(push_n) : '0) - (pop ? CNTW'(pop_n) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign count = cnt_q;
  assign free  = CNTW'(DEPTH) - cnt_q;

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> (CNTW'(push_n) <= free)) else $error("buffer overflow"); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> (CNTW'(pop_n) <= count)) else $error("buffer underflow"); // R6

endmodule

// File: rtl/dma_side_engine.sv
module dma_side_engine
  import dma_pack_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               halt,
  input  logic [AW-1:0]      cfg_addr,
  input  logic               cfg_inc,
  input  logic [1:0]         cfg_size,
  input  logic [BURST_W-1:0] cfg_burst_m1,
  input  logic [CW-1:0]      cfg_bytes,
  input  logic               go,
  input  logic               fire,
  output logic               req,
  output logic [AW-1:0]      addr,
  output logic [1:0]         size,
  output logic               want,
  output logic               fin,
  output logic [CW-1:0]      burst_bytes
);
  localparam int BCW = BURST_W + 1;

  logic [AW-1:0]      addr_q, addr_d;
  logic [CW-1:0]      rem_q, rem_d;
  logic               inc_q, inc_d;
  logic [1:0]         size_q, size_d;
  logic [BURST_W-1:0] bm1_q, bm1_d;
  logic [BCW-1:0]     beats_q, beats_d;
  logic               act_q, act_d;

  logic [2:0]    step;
  logic [CW-1:0] avail, maxb, nb;

  assign step        = size_bytes(size_q);
  assign avail       = rem_q >> size_q;
  assign maxb        = CW'(bm1_q) + CW'(1);
  assign nb          = (avail < maxb) ? avail : maxb;
  assign burst_bytes = nb << size_q;
  assign want        = !act_q && (rem_q >= CW'(step));
  assign fin         = !act_q && (rem_q <  CW'(step));

  always_comb begin
    addr_d  = addr_q;
    rem_d   = rem_q;
    inc_d   = inc_q;
    size_d  = size_q;
    bm1_d   = bm1_q;
    beats_d = beats_q;
    act_d   = act_q;
    if (load) begin
      addr_d  = cfg_addr;
      rem_d   = cfg_bytes;
      inc_d   = cfg_inc;
      size_d  = cfg_size;
      bm1_d   = cfg_burst_m1;
      beats_d = '0;
      act_d   = 1'b0;
    end else if (halt) begin
      rem_d = '0;
      act_d = 1'b0;
    end else if (act_q) begin
      if (fire) begin
        addr_d  = addr_q + (inc_q ? AW'(step) : '0);
        rem_d   = rem_q - CW'(step);
        beats_d = beats_q - BCW'(1);
        if (beats_q == BCW'(1)) act_d = 1'b0;
      end
    end else if (want && go) begin
      act_d   = 1'b1;
      beats_d = BCW'(nb);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rem_q   <= '0;
      inc_q   <= 1'b0;
      size_q  <= 2'd0;
      bm1_q   <= '0;
      beats_q <= '0;
      act_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      inc_q   <= inc_d;
      size_q  <= size_d;
      bm1_q   <= bm1_d;
      beats_q <= beats_d;
      act_q   <= act_d;
    end
  end

  assign req  = act_q;
  assign addr = addr_q;
  assign size = size_q;

  AST_ADDR_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
    (fire && inc_q && !load && !halt) |=> (addr == $past(addr) + AW'($past(step))))
    else $error("address step wrong"); // R5
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !inc_q && !load) |=> $stable(addr)) else $error("frozen address moved"); // R5

endmodule

// File: rtl/dma_pack_stream.sv
module dma_pack_stream
  import dma_pack_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CW          = 16,
  parameter int BURST_W     = 2,
  parameter int FIFO_WORDS  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         cfg_mode,
  input  logic [AW-1:0]      cfg_src_addr,
  input  logic [AW-1:0]      cfg_dst_addr,
  input  logic               cfg_src_inc,
  input  logic               cfg_dst_inc,
  input  logic [1:0]         cfg_src_size,
  input  logic [1:0]         cfg_dst_size,
  input  logic [BURST_W-1:0] cfg_burst_m1,
  input  logic [CW-1:0]      cfg_bytes,
  input  logic               periph_req,
  output logic               rd_req,
  output logic [AW-1:0]      rd_addr,
  output logic [1:0]         rd_size,
  input  logic               rd_gnt,
  input  logic [31:0]        rd_data,
  input  logic               rd_err,
  output logic               wr_req,
  output logic [AW-1:0]      wr_addr,
  output logic [1:0]         wr_size,
  output logic [31:0]        wr_data,
  input  logic               wr_gnt,
  input  logic               wr_err,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               irq
);
  localparam int DEPTH = FIFO_WORDS * 4;
  localparam int CNTW  = $clog2(DEPTH) + 1;

  logic [1:0]      mode_q, mode_d;
  logic            run_q, run_d;
  logic            done_q, done_d;
  logic            err_q, err_d;
  logic            irq_q, irq_d;

  logic            rd_fire, wr_fire, abort;
  logic            rd_go, wr_go;
  logic            rd_want, wr_want, rd_fin, wr_fin;
  logic [CW-1:0]   rd_bb, wr_bb;
  logic [CNTW-1:0] f_count, f_free;
  logic [31:0]     f_head;

  assign rd_fire = rd_req && rd_gnt;
  assign wr_fire = wr_req && wr_gnt;
  assign abort   = (rd_fire && rd_err) || (wr_fire && wr_err);

  // Burst gating: whole-burst reservation plus peripheral pacing
  assign rd_go = run_q && (CW'(f_free) >= rd_bb)
                 && ((mode_q != MODE_P2M) || periph_req);
  assign wr_go = run_q && (CW'(f_count) >= wr_bb)
                 && ((mode_q != MODE_M2P) || periph_req);

  dma_side_engine #(.AW(AW), .CW(CW), .BURST_W(BURST_W)) u_rd_side (
    .clk, .rst_n,
    .load(start), .halt(abort),
    .cfg_addr(cfg_src_addr), .cfg_inc(cfg_src_inc), .cfg_size(cfg_src_size),
    .cfg_burst_m1, .cfg_bytes,
    .go(rd_go), .fire(rd_fire),
    .req(rd_req), .addr(rd_addr), .size(rd_size),
    .want(rd_want), .fin(rd_fin), .burst_bytes(rd_bb)
  );

  dma_side_engine #(.AW(AW), .CW(CW), .BURST_W(BURST_W)) u_wr_side (
    .clk, .rst_n,
    .load(start), .halt(abort),
    .cfg_addr(cfg_dst_addr), .cfg_inc(cfg_dst_inc), .cfg_size(cfg_dst_size),
    .cfg_burst_m1, .cfg_bytes,
    .go(wr_go), .fire(wr_fire),
    .req(wr_req), .addr(wr_addr), .size(wr_size),
    .want(wr_want), .fin(wr_fin), .burst_bytes(wr_bb)
  );

  dma_pack_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n,
    .clr(start),
    .push(rd_fire && !rd_err), .push_n(size_bytes(rd_size)), .push_data(rd_data),
    .pop(wr_fire), .pop_n(size_bytes(wr_size)),
    .head(f_head), .count(f_count), .free(f_free)
  );

  assign wr_data = f_head & lane_mask(wr_size);

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    done_d = done_q;
    err_d  = err_q;
    irq_d  = 1'b0;
    if (start) begin
      mode_d = cfg_mode;
      run_d  = 1'b1;
      done_d = 1'b0;
      err_d  = 1'b0;
    end else if (run_q && abort) begin
      run_d  = 1'b0;
      done_d = 1'b1;
      err_d  = 1'b1;
      irq_d  = 1'b1;
    end else if (run_q && rd_fin && wr_fin) begin
      run_d  = 1'b0;
      done_d = 1'b1;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_M2M;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      done_q <= done_d;
      err_q  <= err_d;
      irq_q  <= irq_d;
    end
  end

  assign busy = run_q;
  assign done = done_q;
  assign err  = err_q;
  assign irq  = irq_q;

  AST_P2M_PACED:  assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_P2M && $rose(rd_req)) |-> $past(periph_req)) else $error("unpaced read burst"); // R2
  AST_M2P_PACED:  assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_M2P && $rose(wr_req)) |-> $past(periph_req)) else $error("unpaced write burst"); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_req && !wr_req)) else $error("request while done"); // R7
  AST_IRQ_PULSE:  assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("irq longer than one cycle"); // R7
  AST_ERR_STOP:   assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort && !start) |=> (!rd_req && !wr_req && err && done)) else $error("no stop on error"); // R8

endmodule

// File: tb/dma_pack_stream_bench.sv
module dma_pack_stream_bench;
  localparam int AW = 32, CW = 16, BW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    cfg_mode, cfg_src_size, cfg_dst_size;
  logic [AW-1:0] cfg_src_addr, cfg_dst_addr;
  logic          cfg_src_inc, cfg_dst_inc;
  logic [BW-1:0] cfg_burst_m1;
  logic [CW-1:0] cfg_bytes;
  logic          periph_req;
  logic          rd_req, rd_gnt, rd_err, wr_req, wr_gnt, wr_err;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [1:0]    rd_size, wr_size;
  logic [31:0]   rd_data, wr_data;
  logic          busy, done, err, irq;

  always #4 clk = ~clk;

  dma_pack_stream #(.AW(AW), .CW(CW), .BURST_W(BW)) u_dma_pack_stream (.*);

  int nchk = 0, nfail = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  // per-vector state
  int v_mode, v_ss, v_ds, v_si, v_di, v_bm1, v_bytes, v_err, v_start;
  int v_src, v_dst;
  int rd_cnt, wr_cnt, last_wr, err_cyc, first_rd_rel, early_rd;
  int addr_bad, size_bad, lane_bad, gotn, win_idx;
  logic [7:0] got [0:127];
  int win_cnt [0:63];

  function automatic logic [7:0] fb(input logic [31:0] a);
    return 8'((a * 29) + (a >> 8) + 7);
  endfunction

  function automatic int nbytes(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Falling-edge port model: grants, read data, pacing, beat recording
  always @(negedge clk) begin
    int rel;
    cyc++;
    rel  = cyc - v_start;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_gnt = (lfsr[1:0] != 2'b00);
    wr_gnt = (lfsr[3:2] != 2'b00);
    rd_err = 1'b0;
    wr_err = 1'b0;
    for (int j = 0; j < 4; j++)
      rd_data[8*j +: 8] = (j < nbytes(int'(rd_size))) ? fb(rd_addr + 32'(j)) : 8'hAA;
    if (rd_req && first_rd_rel < 0) first_rd_rel = rel;
    if (rd_req && rd_gnt) begin
      if (v_err == 1 && rd_cnt == 2) begin rd_err = 1'b1; err_cyc = cyc; end
      if (v_mode == 1 && rel < 50) early_rd++;
      rd_cnt++;
    end
    if (wr_req && wr_gnt) begin
      int dn;
      dn = nbytes(v_ds);
      if (v_err == 2 && wr_cnt == 1) begin wr_err = 1'b1; err_cyc = cyc; end
      if (wr_addr != 32'(v_dst + (v_di != 0 ? wr_cnt * dn : 0))) addr_bad++;
      if (int'(wr_size) != v_ds) size_bad++;
      for (int j = 0; j < 4; j++) begin
        if (j < dn) begin
          if (gotn < 128) got[gotn] = wr_data[8*j +: 8];
          gotn++;
        end else if (wr_data[8*j +: 8] != 8'h00) lane_bad++;
      end
      if (win_idx < 64) win_cnt[win_idx]++;
      last_wr = cyc;
      wr_cnt++;
    end
    case (v_mode)
      1: periph_req = (rel >= 50) && rel[0];
      2: begin
        periph_req = (rel % 60 == 59);
        if (periph_req) win_idx++;
      end
      default: periph_req = 1'b0;
    endcase
  end

  task automatic run_vec(input int mode, ss, ds, si, di, bm1, nb, errm);
    int done_cyc;
    @(negedge clk); #1;
    v_mode = mode; v_ss = ss; v_ds = ds; v_si = si; v_di = di;
    v_bm1 = bm1; v_bytes = nb; v_err = errm;
    v_src = 32'h100 + nchk * 64; v_dst = 32'h8000 + nchk * 64;
    rd_cnt = 0; wr_cnt = 0; last_wr = -1; err_cyc = -1; first_rd_rel = -1;
    early_rd = 0; addr_bad = 0; size_bad = 0; lane_bad = 0; gotn = 0; win_idx = 0;
    for (int p = 0; p < 64; p++) win_cnt[p] = 0;
    cfg_mode = 2'(mode); cfg_src_size = 2'(ss); cfg_dst_size = 2'(ds);
    cfg_src_inc = 1'(si); cfg_dst_inc = 1'(di); cfg_burst_m1 = BW'(bm1);
    cfg_bytes = CW'(nb); cfg_src_addr = 32'(v_src); cfg_dst_addr = 32'(v_dst);
    v_start = cyc;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    done_cyc = -1;
    for (int t = 0; t < 5000; t++) begin
      if (done) begin done_cyc = cyc; break; end
      @(negedge clk); #1;
    end
    chk(done_cyc >= 0, "R7 done reached", done_cyc, 1);
    if (errm != 0) begin
      int rc, wc;
      chk(done_cyc - err_cyc == 1, "R8 done one cycle after error", done_cyc - err_cyc, 1);
      chk(err && irq && !busy, "R8 err/irq flags", {err, irq, busy}, 3'b110);
      rc = rd_cnt; wc = wr_cnt;
      repeat (12) @(negedge clk);
      #1;
      chk(rd_cnt == rc && wr_cnt == wc && !rd_req && !wr_req, "R8 no beats after error",
          (rd_cnt - rc) + (wr_cnt - wc), 0);
    end else if (nb == 0) begin
      chk(done_cyc - v_start == 2 && rd_cnt == 0 && wr_cnt == 0, "R9 zero count",
          done_cyc - v_start, 2);
    end else begin
      int sn, mism;
      sn = nbytes(ss);
      mism = 0;
      if (mode == 0) chk(first_rd_rel == 2, "R2 first read latency", first_rd_rel, 2);
      if (mode == 1) chk(early_rd == 0, "R2 read before periph_req", early_rd, 0);
      chk(gotn == nb, "R4 byte total", gotn, nb);
      for (int k = 0; k < nb && k < 128; k++) begin
        int a;
        a = v_src + (si != 0 ? (k / sn) * sn : 0) + (k % sn);
        if (got[k] != fb(32'(a))) mism++;
      end
      chk(mism == 0, "R4 byte order", mism, 0);
      chk(addr_bad == 0, "R5 write addresses", addr_bad, 0);
      chk(size_bad == 0 && lane_bad == 0, "R3 size code and lanes", size_bad + lane_bad, 0);
      chk(done_cyc - last_wr == 2, "R7 done latency", done_cyc - last_wr, 2);
      chk(irq && !err && !busy, "R7 irq with done", {irq, err, busy}, 3'b100);
      if (mode == 2) begin
        int r, e, wbad;
        r = nb / nbytes(ds);
        wbad = (win_cnt[0] != 0) ? 1 : 0;
        for (int p = 1; p <= win_idx && p < 64; p++) begin
          e = (r < bm1 + 1) ? r : bm1 + 1;
          if (win_cnt[p] != e) wbad++;
          r -= e;
        end
        chk(wbad == 0, "R6 beats per burst", wbad, 0);
      end
    end
    @(negedge clk); #1;
    chk(!irq && done, "R7 irq one cycle, done held", {irq, done}, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_mode = '0; cfg_src_size = '0; cfg_dst_size = '0;
    cfg_src_inc = 1'b0; cfg_dst_inc = 1'b0; cfg_burst_m1 = '0; cfg_bytes = '0;
    cfg_src_addr = '0; cfg_dst_addr = '0; v_mode = 0; v_start = 0; v_err = 0; v_ds = 0;
    v_di = 0; v_dst = 0; win_idx = 0; first_rd_rel = 0;
    repeat (3) @(negedge clk);
    #1;
    chk({rd_req, wr_req, busy, done, err, irq} == 6'b0, "R1 in reset",
        {rd_req, wr_req, busy, done, err, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk({rd_req, wr_req, busy, done, err, irq} == 6'b0, "R1 after reset",
        {rd_req, wr_req, busy, done, err, irq}, 0);
    run_vec(0, 0, 0, 1, 1, 0, 0, 0);  // R9
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 3; s++)
        for (int d = 0; d < 3; d++)
          for (int b = 0; b < 2; b++) begin
            int bm1, si, di;
            bm1 = (b == 0) ? 0 : 3;
            si = (m != 1 && !(m == 0 && bm1 == 3)) ? 1 : 0;
            di = (m != 2) ? 1 : 0;
            run_vec(m, s, d, si, di, bm1, 24, 0);
          end
    run_vec(0, 0, 2, 1, 1, 3, 24, 1);  // R8 read error
    run_vec(0, 2, 1, 1, 1, 1, 24, 2);  // R8 write error
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule